// File: doc/BRIEF.md
# Byte-wide FPGA configuration loader

This block is the hardware master that pushes a configuration image into a target FPGA over its byte-wide slave parallel port. A local agent gives a one-cycle start request with a byte count, and then supplies the image as a valid/ready byte stream. The loader first resets the target's configuration logic by holding the program pin for a set number of cycles. It then waits for the target to report that it is ready, and streams the bytes with one configuration-clock pulse each. Last, it keeps the configuration clock running until the target signals that it is configured.

Each wait point (ready, optional busy stall, completion) is bounded by a cycle-count timeout. When a timeout expires, the load is abandoned and reported as a failure with an abort flag. All pin levels are logical, with 1 meaning asserted. Any inversion that the board needs is outside the block. Every pin output is decoded from registered state, so no target input reaches a pin in the same cycle.

Top module: `cfg_loader`

## Requirements
- R1: Under reset and while idle: program, chip-select, write, stream-ready, finish, ok and abort are all 0, and the configuration clock is 1.
- R2: A start request seen while idle latches the byte count. From the next cycle, program is held at 1 for exactly PROG_CYC cycles, with chip-select and write at 0.
- R3: After program is released, the block holds the pins idle until it samples init high and busy low at a clock edge. It goes on at the first such edge. If the wait counter (0 in the first wait cycle, +1 per cycle) reaches TMO_CYC before that, the load ends as a failure.
- R4: In the byte phase, chip-select, write and the configuration clock are 1 and stream-ready is 1. Exactly one byte is taken per valid/ready handshake, and the count given at start sets how many bytes are taken.
- R5: A taken byte appears on the data pins in the next cycle. The configuration clock is then 0 for HALF_DIV cycles and 1 for HALF_DIV cycles, and the data pins stay unchanged through both halves.
- R6: When BUSY_CHECK is 1 and busy is sampled high at the end of a byte's high half, the block adds further low/high clock pulses with stream-ready at 0 until busy is sampled low at the end of a high half. If the stall counter has reached TMO_CYC at such a check, the load fails.
- R7: After the last byte, and after a busy timeout, chip-select drops first. Write stays 1 for HALF_DIV more cycles and then drops. Chip-select is never 1 while write is 0.
- R8: In the completion wait, the clock is held at 1 for HALF_DIV cycles and done is then checked. While done is low, low/high pulses of HALF_DIV cycles each follow, and done is checked at the end of each high half. If the counter has reached TMO_CYC at a check, the load fails.
- R9: Each load ends with exactly one cycle where finish is 1, and all pins are idle in that cycle. In that cycle ok is 1 on success, or abort is 1 on any timeout; ok and abort are never both 1.
- R10: A start request made while a load is in progress, or during its finish cycle, is ignored. The load in progress keeps its byte count and timing.
- R11: A byte count of 0 skips the byte phase. The block goes from the ready wait straight to the completion wait, and chip-select and write stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle load request |
| len_i | input | LEN_W | Number of image bytes for the load |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| prog_o | output | 1 | Target program (configuration reset) pin |
| cs_o | output | 1 | Target chip-select pin |
| wr_o | output | 1 | Target write-strobe pin |
| cclk_o | output | 1 | Target configuration clock pin |
| data_o | output | 8 | Target data pins |
| init_i | input | 1 | Target init status (1 = ready) |
| busy_i | input | 1 | Target busy status |
| done_i | input | 1 | Target configured status |
| fin_o | output | 1 | One-cycle end-of-load strobe |
| ok_o | output | 1 | Load succeeded (valid with fin_o) |
| abort_o | output | 1 | Load abandoned on a timeout (valid with fin_o) |

## Verification
A wrong phase state or a stale half-period count shows on the configuration clock, chip-select or write pins in the very cycle it arises, because all of them are decoded from state. The bench's per-cycle model therefore catches it at once rather than at the end of the load. A wrong remaining-byte count is seen only when the stream-ready level differs after what should have been the last byte. A timeout counter that is cleared at the wrong moment moves the finish strobe by one or more cycles and can turn ok into abort. The scenarios are built so that each wait point both succeeds and expires at least once.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  // Phases of one configuration load
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a start request
    ST_PROG,   // program pin held
    ST_WRDY,   // waiting for target ready
    ST_LOAD,   // strobes up, accepting a stream byte
    ST_CLO,    // configuration clock low half
    ST_CHI,    // configuration clock high half (decision at its end)
    ST_REL,    // chip-select dropped, write still up
    ST_RPT     // one-cycle result report
  } cfgl_st_e;

  // Purpose of the current clock pulse pair
  typedef enum logic [1:0] {
    PM_BYTE,   // pulse that transfers a byte
    PM_BUSY,   // extra pulse while the target is busy
    PM_DONE    // pulse while waiting for completion
  } cfgl_pm_e;

endpackage

// File: rtl/cfgl_span.sv
// Cycle counter for one phase: cleared on a phase change, saturates at LIMIT-1.
module cfgl_span #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic last
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [W-1:0] END_V = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (cnt_q != END_V);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == END_V);
endmodule

// File: rtl/cfgl_wdog.sv
// Wait-point timeout counter, saturating at LIMIT.
module cfgl_wdog #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr || (cnt_q < LIM_V);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q >= LIM_V);
endmodule

// File: rtl/cfgl_fsm.sv
// Load sequencer: phase state, remaining count and result flag.
module cfgl_fsm
  import cfgl_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int BUSY_CHECK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             s_valid_i,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             prog_last,
  input  logic             half_last,
  input  logic             tmo_exp,
  output logic             seg_clr,
  output logic             tmo_clr,
  output logic             take,
  output logic             s_ready_o,
  output logic             prog_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic             cclk_o,
  output logic             fin_o,
  output logic             ok_o,
  output logic             abort_o
);
  cfgl_st_e         st_q, st_d;
  cfgl_pm_e         pm_q, pm_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             fail_q, fail_d;
  logic             busy_hit;
  logic             last_byte;

  if (BUSY_CHECK != 0) begin : g_busy_chk
    assign busy_hit = busy_i;
  end else begin : g_busy_off
    assign busy_hit = 1'b0;
  end

  assign last_byte = (rem_q == '0);

  always_comb begin
    st_d    = st_q;
    pm_d    = pm_q;
    rem_d   = rem_q;
    fail_d  = fail_q;
    tmo_clr = 1'b0;
    take    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d   = ST_PROG;
        rem_d  = len_i;
        fail_d = 1'b0;
      end
      ST_PROG: if (prog_last) begin
        st_d    = ST_WRDY;
        tmo_clr = 1'b1;
      end
      ST_WRDY: begin
        if (init_i && !busy_i) begin
          if (last_byte) begin
            st_d    = ST_CHI;
            pm_d    = PM_DONE;
            tmo_clr = 1'b1;
          end else begin
            st_d = ST_LOAD;
          end
        end else if (tmo_exp) begin
          fail_d = 1'b1;
          st_d   = ST_RPT;
        end
      end
      ST_LOAD: if (s_valid_i) begin
        take  = 1'b1;
        rem_d = rem_q - 1'b1;
        st_d  = ST_CLO;
        pm_d  = PM_BYTE;
      end
      ST_CLO: if (half_last) st_d = ST_CHI;
      ST_CHI: if (half_last) begin
        unique case (pm_q)
          PM_BYTE: begin
            if (busy_hit) begin
              st_d    = ST_CLO;
              pm_d    = PM_BUSY;
              tmo_clr = 1'b1;
            end else begin
              st_d = last_byte ? ST_REL : ST_LOAD;
            end
          end
          PM_BUSY: begin
            if (!busy_hit) st_d = last_byte ? ST_REL : ST_LOAD;
            else if (tmo_exp) begin
              fail_d = 1'b1;
              st_d   = ST_REL;
            end else st_d = ST_CLO;
          end
          default: begin
            if (done_i) st_d = ST_RPT;
            else if (tmo_exp) begin
              fail_d = 1'b1;
              st_d   = ST_RPT;
            end else st_d = ST_CLO;
          end
        endcase
      end
      ST_REL: if (half_last) begin
        if (fail_q) st_d = ST_RPT;
        else begin
          st_d    = ST_CHI;
          pm_d    = PM_DONE;
          tmo_clr = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    seg_clr = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pm_q   <= PM_BYTE;
      rem_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pm_q   <= pm_d;
      rem_q  <= rem_d;
      fail_q <= fail_d;
    end
  end

  // Pin decode from registered state only
  always_comb begin
    prog_o    = (st_q == ST_PROG);
    cs_o      = (st_q == ST_LOAD) ||
                (((st_q == ST_CLO) || (st_q == ST_CHI)) && (pm_q != PM_DONE));
    wr_o      = cs_o || (st_q == ST_REL);
    cclk_o    = (st_q != ST_CLO);
    s_ready_o = (st_q == ST_LOAD);
    fin_o     = (st_q == ST_RPT);
    ok_o      = fin_o && !fail_q;
    abort_o   = fin_o && fail_q;
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int HALF_DIV   = 4,
  parameter int PROG_CYC   = 64,
  parameter int TMO_CYC    = 1000000,
  parameter int LEN_W      = 24,
  parameter int BUSY_CHECK = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             s_valid_i,
  input  logic [7:0]       s_data_i,
  output logic             s_ready_o,
  output logic             prog_o,
  output logic             cs_o,
  output logic             wr_o,
  output logic             cclk_o,
  output logic [7:0]       data_o,
  input  logic             init_i,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             fin_o,
  output logic             ok_o,
  output logic             abort_o
);
  logic [1:0] rsync_q;
  logic       rst_q_n;
  logic       seg_clr, tmo_clr, take;
  logic       prog_last, half_last, tmo_exp;
  logic [7:0] data_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  cfgl_span #(.LIMIT(PROG_CYC)) u_prog_span (
    .clk(clk), .rst_n(rst_q_n), .clr(seg_clr), .last(prog_last)
  );

  cfgl_span #(.LIMIT(HALF_DIV)) u_half_span (
    .clk(clk), .rst_n(rst_q_n), .clr(seg_clr), .last(half_last)
  );

  cfgl_wdog #(.LIMIT(TMO_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_q_n), .clr(tmo_clr), .expired(tmo_exp)
  );

  cfgl_fsm #(.LEN_W(LEN_W), .BUSY_CHECK(BUSY_CHECK)) u_fsm (
    .clk(clk), .rst_n(rst_q_n), .start_i(start_i), .len_i(len_i),
    .s_valid_i(s_valid_i), .init_i(init_i), .busy_i(busy_i),
    .done_i(done_i), .prog_last(prog_last), .half_last(half_last),
    .tmo_exp(tmo_exp), .seg_clr(seg_clr), .tmo_clr(tmo_clr), .take(take),
    .s_ready_o(s_ready_o), .prog_o(prog_o), .cs_o(cs_o), .wr_o(wr_o),
    .cclk_o(cclk_o), .fin_o(fin_o), .ok_o(ok_o), .abort_o(abort_o)
  );

  // Data pins: load on handshake only
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)  data_q <= '0;
    else if (take) data_q <= s_data_i;
  end
  assign data_o = data_q;
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       s_ready_o,
  input logic       prog_o,
  input logic       cs_o,
  input logic       wr_o,
  input logic       cclk_o,
  input logic [7:0] data_o,
  input logic       fin_o,
  input logic       ok_o,
  input logic       abort_o
);
  // R2: no strobes while the target is held in program
  a_r2_prog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> (!cs_o && !wr_o && !s_ready_o));

  // R4: stream accepted only with strobes and clock up
  a_r4_ready_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (cs_o && wr_o && cclk_o && !prog_o));

  // R5: data pins hold through the low half
  a_r5_data_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_o && !cclk_o && !$past(cclk_o)) |-> $stable(data_o));

  // R5: data pins hold across the capturing rise
  a_r5_data_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cclk_o) && cs_o) |-> $stable(data_o));

  // R7: chip-select never without write
  a_r7_cs_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |-> wr_o);

  // R7: write drops only after chip-select has dropped
  a_r7_wr_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_o) |-> !$past(cs_o));

  // R9: result flags only in the finish cycle, exactly one of them
  a_r9_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o || abort_o) |-> (fin_o && (ok_o != abort_o)));

  // R9: finish lasts one cycle
  a_r9_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);

  // R9: pins idle while reporting
  a_r9_fin_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (!cs_o && !wr_o && !prog_o && cclk_o));
endmodule

bind cfg_loader cfgl_checker u_cfgl_checker (
  .clk(clk), .rst_n(rst_n), .s_ready_o(s_ready_o), .prog_o(prog_o),
  .cs_o(cs_o), .wr_o(wr_o), .cclk_o(cclk_o), .data_o(data_o),
  .fin_o(fin_o), .ok_o(ok_o), .abort_o(abort_o)
);

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int H    = 2;
  localparam int PROG = 3;
  localparam int TMO  = 24;
  localparam int LW   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [LW-1:0] len_i;
  logic s_valid_i;
  logic [7:0] s_data_i;
  logic s_ready_o, prog_o, cs_o, wr_o, cclk_o, fin_o, ok_o, abort_o;
  logic [7:0] data_o;
  logic init_i, busy_i, done_i;

  always #2.5ns clk = ~clk;

  cfg_loader #(.HALF_DIV(H), .PROG_CYC(PROG), .TMO_CYC(TMO), .LEN_W(LW),
               .BUSY_CHECK(1)) u_cfg_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
    .prog_o(prog_o), .cs_o(cs_o), .wr_o(wr_o), .cclk_o(cclk_o),
    .data_o(data_o), .init_i(init_i), .busy_i(busy_i), .done_i(done_i),
    .fin_o(fin_o), .ok_o(ok_o), .abort_o(abort_o)
  );

  int errors = 0;
  int checks = 0;
  bit live = 0;

  // expected pins from the reference model
  bit e_prog = 0, e_cs = 0, e_wr = 0, e_cclk = 1, e_rdy = 0;
  bit e_fin = 0, e_ok = 0, e_abort = 0;
  logic [7:0] e_d = '0;

  // target and stream knobs / monitors
  bit k_ien, k_den;
  int k_idly, k_bat, k_dafter, busy_left;
  int since = 0, dpl = 0, bytes_taken = 0, tick = 0;
  int prog_cyc = 0, rise_cs = 0, fin_cnt = 0;
  bit cs_seen = 0, last_ok = 0, last_abort = 0, prev_cclk = 1, pend = 0;
  logic [7:0] tx_q[$];

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  task automatic cy(input bit p, input bit c, input bit w, input bit k,
                    input bit r, input bit f, input bit o, input bit a);
    e_prog = p; e_cs = c; e_wr = w; e_cclk = k; e_rdy = r;
    e_fin = f; e_ok = o; e_abort = a;
    @(posedge clk);
  endtask

  task automatic pulse(input bit strobes);
    repeat (H) cy(0, strobes, strobes, 0, 0, 0, 0, 0);
    repeat (H) cy(0, strobes, strobes, 1, 0, 0, 0, 0);
  endtask

  initial begin : model
    int n, k, c;
    bit fl;
    wait (rst_n === 1'b1);
    forever begin
      cy(0, 0, 0, 1, 0, 0, 0, 0);
      if (start_i !== 1'b1) continue;
      n = int'(len_i);
      fl = 0;
      repeat (PROG) cy(1, 0, 0, 1, 0, 0, 0, 0);
      k = 0;
      forever begin
        cy(0, 0, 0, 1, 0, 0, 0, 0);
        if (init_i && !busy_i) break;
        if (k >= TMO) begin fl = 1; break; end
        k++;
      end
      if (!fl && n > 0) begin
        while (n > 0 && !fl) begin
          forever begin
            cy(0, 1, 1, 1, 1, 0, 0, 0);
            if (s_valid_i) break;
          end
          e_d = s_data_i;
          n--;
          pulse(1);
          if (busy_i) begin
            c = 0;
            forever begin
              pulse(1);
              c += 2 * H;
              if (!busy_i) break;
              if (c - 1 >= TMO) begin fl = 1; break; end
            end
          end
        end
        repeat (H) cy(0, 0, 1, 1, 0, 0, 0, 0);
      end
      if (!fl) begin
        repeat (H) cy(0, 0, 0, 1, 0, 0, 0, 0);
        c = H;
        forever begin
          if (done_i) break;
          if (c - 1 >= TMO) begin fl = 1; break; end
          pulse(0);
          c += 2 * H;
        end
      end
      cy(0, 0, 0, 1, 0, 1, !fl, fl);
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  initial begin : compare
    bit bad;
    forever begin
      @(negedge clk);
      if (live) begin
        checks++;
        bad = 0;
        if (prog_o !== e_prog) begin bad = 1; $display("FAIL R2 prog: actual=%0d expected=%0d", prog_o, e_prog); end
        if (cs_o !== e_cs) begin bad = 1; $display("FAIL R7 cs: actual=%0d expected=%0d", cs_o, e_cs); end
        if (wr_o !== e_wr) begin bad = 1; $display("FAIL R7 wr: actual=%0d expected=%0d", wr_o, e_wr); end
        if (cclk_o !== e_cclk) begin bad = 1; $display("FAIL R5 cclk: actual=%0d expected=%0d", cclk_o, e_cclk); end
        if (s_ready_o !== e_rdy) begin bad = 1; $display("FAIL R4 ready: actual=%0d expected=%0d", s_ready_o, e_rdy); end
        if (data_o !== e_d) begin bad = 1; $display("FAIL R5 data: actual=%0d expected=%0d", data_o, e_d); end
        if (fin_o !== e_fin) begin bad = 1; $display("FAIL R9 fin: actual=%0d expected=%0d", fin_o, e_fin); end
        if (ok_o !== e_ok) begin bad = 1; $display("FAIL R9 ok: actual=%0d expected=%0d", ok_o, e_ok); end
        if (abort_o !== e_abort) begin bad = 1; $display("FAIL R9 abort: actual=%0d expected=%0d", abort_o, e_abort); end
        if (bad) errors++;
      end
      if (prog_o) prog_cyc++;
      if (cclk_o && !prev_cclk && cs_o) rise_cs++;
      if (cs_o) cs_seen = 1;
      if (fin_o) begin fin_cnt++; last_ok = ok_o; last_abort = abort_o; end
    end
  end

  // ---------------- target and stream drivers ----------------
  initial begin : drive
    init_i = 0; busy_i = 0; done_i = 0; s_valid_i = 0; s_data_i = '0;
    forever begin
      @(negedge clk);
      // target status
      if (prog_o) begin since = 0; dpl = 0; end else since++;
      init_i = k_ien && (since >= k_idly) && !prog_o;
      if (k_bat > 0 && bytes_taken == k_bat && busy_left > 0) begin
        busy_i = 1; busy_left--;
      end else busy_i = 0;
      if (cclk_o && !prev_cclk && !cs_o && !wr_o) dpl++;
      done_i = k_den && (dpl >= k_dafter);
      prev_cclk = cclk_o;
      // stream
      if (pend) begin void'(tx_q.pop_front()); bytes_taken++; end
      tick++;
      s_valid_i = (tx_q.size() > 0) && ((tick % 3) != 2);
      s_data_i  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
      pend = s_valid_i && s_ready_o;
    end
  end

  task automatic run(input int n, input bit ien, input int idly,
                     input int bat, input int blen, input bit den,
                     input int dafter, input bit poke, input bit exp_ok,
                     input string req);
    int f0;
    @(negedge clk);
    tx_q.delete();
    for (int i = 0; i < n; i++) tx_q.push_back(8'(8'h3C + 37 * i));
    k_ien = ien; k_idly = idly; k_bat = bat; busy_left = blen;
    k_den = den; k_dafter = dafter;
    bytes_taken = 0; prog_cyc = 0; rise_cs = 0; cs_seen = 0;
    f0 = fin_cnt;
    start_i = 1; len_i = LW'(n);
    @(negedge clk);
    start_i = 0;
    if (poke) begin
      repeat (12) @(negedge clk);
      start_i = 1; len_i = 8'd7;        // R10: must be ignored
      @(negedge clk);
      start_i = 0;
    end
    while (fin_cnt == f0) @(negedge clk);
    if (poke) begin
      start_i = 1; len_i = 8'd7;        // R10: start in the finish cycle
      @(negedge clk);
      start_i = 0;
    end
    repeat (4) @(negedge clk);
    chk(fin_cnt - f0 == 1, "R10", "finish strobes", fin_cnt - f0, 1);
    chk(last_ok == exp_ok, req, "ok result", last_ok, exp_ok);
    chk(last_abort == !exp_ok, "R9", "abort result", last_abort, !exp_ok);
    chk(prog_cyc == PROG, "R2", "program cycles", prog_cyc, PROG);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    k_ien = 0; k_idly = 0; k_bat = 0; busy_left = 0; k_den = 0; k_dafter = 0;
    start_i = 0; len_i = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    chk(!prog_o && !cs_o && !wr_o && cclk_o && !s_ready_o && !fin_o && !abort_o,
        "R1", "idle pins in reset", {prog_o, cs_o, wr_o, cclk_o}, 4'b0001);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(!prog_o && !cs_o && cclk_o && !fin_o, "R1", "idle pins after reset",
        {prog_o, cs_o, wr_o, cclk_o}, 4'b0001);
    live = 1;

    // R4 R5 R8: plain load
    run(4, 1, 5, 0, 0, 1, 2, 0, 1, "R8");
    chk(bytes_taken == 4, "R4", "bytes taken", bytes_taken, 4);
    chk(rise_cs == 4, "R5", "byte clock rises", rise_cs, 4);

    // R6 R10: busy stall with ignored restart
    run(3, 1, 3, 2, 6, 1, 1, 1, 1, "R6");
    chk(bytes_taken == 3, "R10", "bytes taken despite restart", bytes_taken, 3);
    chk(rise_cs > 3, "R6", "stall pulses present", rise_cs, 4);

    // R3: target never ready
    run(2, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    chk(bytes_taken == 0, "R3", "no bytes after ready timeout", bytes_taken, 0);

    // R8: completion never reported
    run(2, 1, 2, 0, 0, 0, 0, 0, 0, "R8");

    // R6: busy stuck
    run(3, 1, 2, 1, 1000, 1, 0, 0, 0, "R6");
    chk(bytes_taken == 1, "R6", "bytes before busy timeout", bytes_taken, 1);

    // R11: zero-length load
    run(0, 1, 4, 0, 0, 1, 1, 0, 1, "R11");
    chk(!cs_seen, "R11", "chip-select seen", cs_seen, 0);

    live = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule